// File: doc/BRIEF.md
# Serial Debug Monitor Entry Controller

This block sits beside the reset logic and decides, each time the reset pin is released, whether the chip boots into a serial debug monitor instead of running normally. The decision rests on whether the power-on reset caused the reset, on whether the reset vector bytes are still blank, on the level code of the interrupt request pin, and on a clock-select pin. The chosen clock source is reported to the clock generator. For a short guard window after release, the shared serial pin must stay high. If it does not, monitor entry is dropped.

Once in monitor mode, the block listens on the single-wire, half-duplex serial pin. It collects a fixed number of security bytes and hands the concatenated value to an external comparator. It then pulls the open-drain line low for a break of ten bit times. When the line is released it raises a ready pulse and latches the comparator's pass/fail answer. Command handling and the security comparison itself live outside the block. The serial pin input is assumed to be synchronised to the bus clock already. `baud_div` sets the bus cycles per bit and is chosen by the integrator so that the line runs at 9600 baud for whichever clock source entry selected.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Monitor entry is considered only when `por_flag` is high at the clock edge that first sees `rst_pin` high. Otherwise the block stays inactive until `rst_pin` goes low again.
- R3: With `vec_erased` low, entry needs `irq_lvl` = 2'b10 (test level). `ref_fast` then equals `clk_sel` (1 selects the 9.8304 MHz reference, 0 the 4.9152 MHz one) and `use_int_clk` is 0. Any other code gives no entry.
- R4: With `vec_erased` high, `irq_lvl` = 2'b01 (normal high) enters with `ref_fast`=1 and `use_int_clk`=0. `irq_lvl` = 2'b00 (low) enters with `use_int_clk`=1 and `ref_fast`=0. Codes 2'b10 and 2'b11 give no entry. Both clock outputs are 0 whenever no entry is pending or active.
- R5: Let G be the edge that sees the release. `ser_in` is sampled at edges G+1 through G+24, and a single low sample abandons entry. If all 24 samples are high, `mon_active` is 1 from edge G+24 on. A low sample at G+25 or later does not cancel entry.
- R6: Each byte is a low start bit, 8 data bits LSB first and a stop bit, with each bit lasting `baud_div` cycles (`baud_div` even, at least 4). Take M = `baud_div`/2 and let E0 be the first edge that sees the start bit low. Bit k is decided by a majority of the samples at edges E0+k·`baud_div`+M−1, +M and +M+1. A start bit that votes high is discarded.
- R7: A byte whose stop bit votes low gives a one-cycle `frame_err` pulse after edge E0+9·`baud_div`+M+1. The byte still counts toward the eight.
- R8: One cycle after the eighth byte's stop decision, `sec_valid` pulses for one cycle. At that point `sec_data` holds the eight bytes, with the first received byte in bits [7:0] and byte i in bits [8i+7:8i].
- R9: `ser_pull_low` is 1 for exactly 10·`baud_div` cycles, starting in the `sec_valid` cycle. At all other times the line is released.
- R10: `cmd_ready` pulses for one cycle in the first cycle after the break, with the line released. `sec_unlocked` takes the value `sec_pass` has in that cycle and holds it until `rst_pin` goes low.
- R11: A single-cycle glitch on one of the three samples of a bit does not change the received value.
- R12: Driving `rst_pin` low clears `mon_active` and the clock outputs one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_flag | input | 1 | High when the current reset came from power-on |
| rst_pin | input | 1 | Reset pin level, high when released |
| irq_lvl | input | 2 | Interrupt pin level code: 00 low, 01 normal high, 10 test level, 11 invalid |
| clk_sel | input | 1 | Clock-select pin for the non-erased entry case |
| vec_erased | input | 1 | Both reset vector bytes read as erased |
| baud_div | input | DIV_W | Bus cycles per serial bit |
| sec_pass | input | 1 | Result from the external security comparator |
| ser_in | input | 1 | Serial pin level as read back |
| mon_active | output | 1 | Monitor mode entered |
| use_int_clk | output | 1 | Select the internal clock generator |
| ref_fast | output | 1 | External reference is the 9.8304 MHz one |
| ser_pull_low | output | 1 | Pull the open-drain serial pin low |
| frame_err | output | 1 | One-cycle stop-bit error pulse |
| sec_valid | output | 1 | One-cycle strobe, all security bytes received |
| sec_data | output | 64 | Captured security bytes |
| cmd_ready | output | 1 | One-cycle pulse, ready for the first command |
| sec_unlocked | output | 1 | Latched comparator result |

## Verification
Every result has a fixed latency, counted from the edge that sees its cause. The clock outputs appear right after the release edge G, and `mon_active` appears after G+24. `frame_err` appears after E0+9·`baud_div`+M+1, `sec_valid` and the start of the break one edge after that, and `cmd_ready` 10·`baud_div` cycles after the break starts. `sec_unlocked` settles one edge after `cmd_ready`. The bench records these edge numbers when it starts each stimulus. It compares every registered output against them on each falling edge, which is half a cycle after the edge that could change the output. Guard-window boundaries are exercised at G+10, at G+24 and at G+25.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_RX,
    ST_BRK,
    ST_RDY,
    ST_OFF
  } mon_state_e;

  typedef enum logic [1:0] {
    IRQ_LOW  = 2'b00,
    IRQ_HIGH = 2'b01,
    IRQ_TEST = 2'b10,
    IRQ_BAD  = 2'b11
  } irq_code_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mon_entry_decode.sv
module mon_entry_decode
  import mon_entry_pkg::*;
(
  input  logic       por,
  input  logic [1:0] irq,
  input  logic       erased,
  input  logic       csel,
  output logic       enter_ok,
  output logic       int_clk,
  output logic       fast_ref
);

  irq_code_e code;
  assign code = irq_code_e'(irq);

  always_comb begin
    enter_ok = 1'b0;
    int_clk  = 1'b0;
    fast_ref = 1'b0;
    if (por) begin
      if (!erased) begin
        if (code == IRQ_TEST) begin
          enter_ok = 1'b1;
          fast_ref = csel;
        end
      end else begin
        case (code)
          IRQ_HIGH: begin
            enter_ok = 1'b1;
            fast_ref = 1'b1;
          end
          IRQ_LOW: begin
            enter_ok = 1'b1;
            int_clk  = 1'b1;
          end
          default: enter_ok = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/mon_rx.sv
module mon_rx
  import mon_entry_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ser,
  input  logic [DIV_W-1:0] div,
  output logic             done,
  output logic [7:0]       data,
  output logic             ferr
);

  logic             busy_q, busy_d;
  logic [DIV_W-1:0] p_q, p_d;
  logic [3:0]       k_q, k_d;
  logic             s1_q, s1_d, s2_q, s2_d;
  logic [7:0]       sh_q, sh_d;
  logic             done_q, done_d;
  logic [7:0]       data_q, data_d;
  logic             ferr_q, ferr_d;

  logic [DIV_W-1:0] mid, mid_lo, mid_hi, last_p;
  logic             vote;

  assign mid    = div >> 1;
  assign mid_lo = mid - DIV_W'(1);
  assign mid_hi = mid + DIV_W'(1);
  assign last_p = div - DIV_W'(1);
  assign vote   = vote3(s1_q, s2_q, ser);

  always_comb begin
    busy_d = busy_q;
    p_d    = p_q;
    k_d    = k_q;
    s1_d   = s1_q;
    s2_d   = s2_q;
    sh_d   = sh_q;
    data_d = data_q;
    done_d = 1'b0;
    ferr_d = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (!ser) begin
        busy_d = 1'b1;
        p_d    = DIV_W'(1);
        k_d    = 4'd0;
      end
    end else begin
      if (p_q == last_p) begin
        p_d = '0;
        k_d = k_q + 4'd1;
      end else begin
        p_d = p_q + DIV_W'(1);
      end
      if (p_q == mid_lo) s1_d = ser;
      if (p_q == mid)    s2_d = ser;
      if (p_q == mid_hi) begin
        if (k_q == 4'd0) begin
          if (vote) busy_d = 1'b0;
        end else if (k_q <= 4'd8) begin
          sh_d = {vote, sh_q[7:1]};
        end else begin
          busy_d = 1'b0;
          done_d = 1'b1;
          data_d = sh_q;
          ferr_d = ~vote;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      p_q    <= '0;
      k_q    <= 4'd0;
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      sh_q   <= 8'd0;
      done_q <= 1'b0;
      data_q <= 8'd0;
      ferr_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      p_q    <= p_d;
      k_q    <= k_d;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      data_q <= data_d;
      ferr_q <= ferr_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign ferr = ferr_q;

  // R6: a finished byte frees the receiver, so completions never come back to back
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/mon_brk.sv
module mon_brk #(
  parameter int BITS  = 10,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             active,
  output logic             done
);

  localparam int BW = $clog2(BITS + 1);

  logic             act_q, act_d;
  logic [DIV_W-1:0] p_q, p_d;
  logic [BW-1:0]    b_q, b_d;
  logic             done_q, done_d;

  always_comb begin
    act_d  = act_q;
    p_d    = p_q;
    b_d    = b_q;
    done_d = 1'b0;
    if (clr) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d = 1'b1;
      p_d   = '0;
      b_d   = '0;
    end else if (act_q) begin
      if (p_q == div - DIV_W'(1)) begin
        p_d = '0;
        if (b_q == BW'(BITS - 1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          b_d = b_q + BW'(1);
        end
      end else begin
        p_d = p_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      p_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      p_q    <= p_d;
      b_q    <= b_d;
      done_q <= done_d;
    end
  end

  assign active = act_q;
  assign done   = done_q;

  // R9: the end-of-break pulse comes exactly when the line is let go
  assert_break_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!act_q && $past(act_q)));

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int GUARD_CYC = 24,
  parameter int SEC_BYTES = 8,
  parameter int BRK_BITS  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   por_flag,
  input  logic                   rst_pin,
  input  logic [1:0]             irq_lvl,
  input  logic                   clk_sel,
  input  logic                   vec_erased,
  input  logic [DIV_W-1:0]       baud_div,
  input  logic                   sec_pass,
  input  logic                   ser_in,
  output logic                   mon_active,
  output logic                   use_int_clk,
  output logic                   ref_fast,
  output logic                   ser_pull_low,
  output logic                   frame_err,
  output logic                   sec_valid,
  output logic [8*SEC_BYTES-1:0] sec_data,
  output logic                   cmd_ready,
  output logic                   sec_unlocked
);

  localparam int SEC_W  = 8 * SEC_BYTES;
  localparam int GCNT_W = $clog2(GUARD_CYC + 1);
  localparam int BCNT_W = $clog2(SEC_BYTES + 1);

  mon_state_e        state_q, state_d;
  logic              rp_q;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic              valid_q, valid_d;
  logic              int_q, int_d;
  logic              fast_q, fast_d;
  logic              unl_q, unl_d;

  logic       dec_ok, dec_int, dec_fast;
  logic       rx_done, rx_ferr;
  logic [7:0] rx_byte;
  logic       brk_start, brk_active, brk_done;

  mon_entry_decode u_decode (
    .por      (por_flag),
    .irq      (irq_lvl),
    .erased   (vec_erased),
    .csel     (clk_sel),
    .enter_ok (dec_ok),
    .int_clk  (dec_int),
    .fast_ref (dec_fast)
  );

  mon_rx #(.DIV_W(DIV_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_q == ST_RX),
    .ser   (ser_in),
    .div   (baud_div),
    .done  (rx_done),
    .data  (rx_byte),
    .ferr  (rx_ferr)
  );

  mon_brk #(.BITS(BRK_BITS), .DIV_W(DIV_W)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~rst_pin),
    .start  (brk_start),
    .div    (baud_div),
    .active (brk_active),
    .done   (brk_done)
  );

  always_comb begin
    state_d   = state_q;
    gcnt_d    = gcnt_q;
    bcnt_d    = bcnt_q;
    sec_d     = sec_q;
    int_d     = int_q;
    fast_d    = fast_q;
    unl_d     = unl_q;
    valid_d   = 1'b0;
    brk_start = 1'b0;
    if (!rst_pin) begin
      state_d = ST_IDLE;
      int_d   = 1'b0;
      fast_d  = 1'b0;
      unl_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!rp_q) begin
            if (dec_ok) begin
              state_d = ST_GUARD;
              gcnt_d  = '0;
              int_d   = dec_int;
              fast_d  = dec_fast;
            end else begin
              state_d = ST_OFF;
            end
          end
        end
        ST_GUARD: begin
          if (!ser_in) begin
            state_d = ST_OFF;
            int_d   = 1'b0;
            fast_d  = 1'b0;
          end else if (gcnt_q == GCNT_W'(GUARD_CYC - 1)) begin
            state_d = ST_RX;
            bcnt_d  = '0;
          end else begin
            gcnt_d = gcnt_q + GCNT_W'(1);
          end
        end
        ST_RX: begin
          if (rx_done) begin
            sec_d = {rx_byte, sec_q[SEC_W-1:8]};
            if (bcnt_q == BCNT_W'(SEC_BYTES - 1)) begin
              state_d   = ST_BRK;
              valid_d   = 1'b1;
              brk_start = 1'b1;
            end else begin
              bcnt_d = bcnt_q + BCNT_W'(1);
            end
          end
        end
        ST_BRK: begin
          if (brk_done) begin
            state_d = ST_RDY;
            unl_d   = sec_pass;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rp_q    <= 1'b0;
      gcnt_q  <= '0;
      bcnt_q  <= '0;
      sec_q   <= '0;
      valid_q <= 1'b0;
      int_q   <= 1'b0;
      fast_q  <= 1'b0;
      unl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rp_q    <= rst_pin;
      gcnt_q  <= gcnt_d;
      bcnt_q  <= bcnt_d;
      sec_q   <= sec_d;
      valid_q <= valid_d;
      int_q   <= int_d;
      fast_q  <= fast_d;
      unl_q   <= unl_d;
    end
  end

  assign mon_active   = (state_q == ST_RX) || (state_q == ST_BRK) || (state_q == ST_RDY);
  assign use_int_clk  = int_q;
  assign ref_fast     = fast_q;
  assign ser_pull_low = brk_active;
  assign frame_err    = rx_ferr;
  assign sec_valid    = valid_q;
  assign sec_data     = sec_q;
  assign cmd_ready    = brk_done;
  assign sec_unlocked = unl_q;

  // R2: a guard phase only ever starts from a power-on reset
  assert_por_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GUARD && $past(state_q) == ST_IDLE) |-> $past(por_flag));

  // R5: leaving the guard window toward reception needs a high line on its last edge
  assert_guard_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX && $past(state_q) == ST_GUARD) |-> $past(ser_in));

  // R4: the two clock choices exclude each other
  assert_clk_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_int_clk && ref_fast));

  // R8: the security strobe is a single cycle
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |=> !sec_valid);

  // R9: the line is pulled only while the sequencer sits in the break phase
  assert_pull_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_pull_low |-> (state_q == ST_BRK));

  // R10: readiness comes with a released line straight after the break
  assert_ready_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ser_pull_low && $past(ser_pull_low)));

endmodule

// File: tb/mon_entry_ctrl_test.sv
module mon_entry_ctrl_test;

  localparam int D     = 16;
  localparam int M     = D / 2;
  localparam int GUARD = 24;
  localparam int BIG   = 32'h7fffffff;

  logic        clk = 1'b0;
  logic        rst_n, por_flag, rst_pin, clk_sel, vec_erased, sec_pass, host;
  logic [1:0]  irq_lvl;
  logic [15:0] baud_div;
  logic        ser_pin;
  logic        mon_active, use_int_clk, ref_fast, ser_pull_low, frame_err;
  logic        sec_valid, cmd_ready, sec_unlocked;
  logic [63:0] sec_data;

  assign ser_pin = host & ~ser_pull_low;

  mon_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .por_flag(por_flag), .rst_pin(rst_pin),
    .irq_lvl(irq_lvl), .clk_sel(clk_sel), .vec_erased(vec_erased),
    .baud_div(baud_div), .sec_pass(sec_pass), .ser_in(ser_pin),
    .mon_active(mon_active), .use_int_clk(use_int_clk), .ref_fast(ref_fast),
    .ser_pull_low(ser_pull_low), .frame_err(frame_err), .sec_valid(sec_valid),
    .sec_data(sec_data), .cmd_ready(cmd_ready), .sec_unlocked(sec_unlocked)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;
  int act_on = BIG, act_off = BIG, pull_from = BIG, pull_to = BIG;
  int valid_at = BIG, rdy_at = BIG;
  int ferr_q[$];
  logic [63:0] exp_sec = '0;
  string sec_tag = "R8";

  function automatic void chk(string req, string name, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, name, act, exp, cyc);
    end
  endfunction

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (model_on) begin
      logic e_fe;
      e_fe = 1'b0;
      foreach (ferr_q[i]) if (ferr_q[i] == cyc) e_fe = 1'b1;
      chk("R5/R12", "mon_active", 64'(mon_active), 64'(cyc >= act_on && cyc < act_off));
      chk("R9", "ser_pull_low", 64'(ser_pull_low), 64'(cyc >= pull_from && cyc < pull_to));
      chk("R8", "sec_valid", 64'(sec_valid), 64'(cyc == valid_at));
      chk("R10", "cmd_ready", 64'(cmd_ready), 64'(cyc == rdy_at));
      chk("R7", "frame_err", 64'(frame_err), 64'(e_fe));
      if (cyc == valid_at) chk(sec_tag, "sec_data R6", sec_data, exp_sec);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished cycle=%0d", cyc);
      summary();
    end
  end

  task automatic pin_reset();
    @(negedge clk);
    rst_pin = 1'b0;
    act_off = cyc + 1;
    repeat (4) @(negedge clk);
    act_on = BIG; act_off = BIG; pull_from = BIG; pull_to = BIG;
    valid_at = BIG; rdy_at = BIG;
    chk("R12", "use_int_clk", 64'(use_int_clk), 0);
    chk("R12", "ref_fast", 64'(ref_fast), 0);
  endtask

  task automatic enter(input bit por, input logic [1:0] irq, input bit ers, input bit cs,
                       input bit expect_in, input int abort_at, input bit e_int, input bit e_fast,
                       input string req);
    int g;
    bit keep;
    por_flag = por; irq_lvl = irq; vec_erased = ers; clk_sel = cs; host = 1'b1;
    @(negedge clk);
    rst_pin = 1'b1;
    g = cyc + 1;
    keep = expect_in && (abort_at == 0 || abort_at > GUARD);
    if (keep) act_on = g + GUARD;
    if (abort_at > 0) begin
      repeat (abort_at) @(negedge clk);
      host = 1'b0;
      @(negedge clk);
      host = 1'b1;
    end
    while (cyc < g + 40) @(negedge clk);
    chk(req, "use_int_clk", 64'(use_int_clk), 64'(keep ? e_int : 1'b0));
    chk(req, "ref_fast", 64'(ref_fast), 64'(keep ? e_fast : 1'b0));
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_hi, input int gk,
                           input bit last, input bit live);
    int e0, es;
    logic lvl;
    e0 = cyc + 1;
    es = e0 + 9 * D + M + 1;
    if (live && !stop_hi) ferr_q.push_back(es);
    if (last) begin
      valid_at = es + 1; pull_from = es + 1; pull_to = es + 1 + 10 * D;
      rdy_at = es + 1 + 10 * D;
    end
    for (int k = 0; k < 10; k++) begin
      lvl = (k == 0) ? 1'b0 : (k == 9) ? stop_hi : b[k-1];
      for (int p = 0; p < D; p++) begin
        host = (k == gk && p == M) ? ~lvl : lvl;
        @(negedge clk);
      end
    end
    host = 1'b1;
    if (!stop_hi) repeat (2 * D) @(negedge clk);
  endtask

  task automatic run_bytes(input int seed, input int fe_idx, input int gl_byte,
                           input int gl_k, input bit live, input bit e_unl);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      b = 8'((seed * 29 + i * 71) ^ 8'h5A);
      exp_sec[8*i +: 8] = b;
    end
    for (int i = 0; i < 8; i++) begin
      send_byte(exp_sec[8*i +: 8], i != fe_idx, (i == gl_byte) ? gl_k : -1, live && i == 7, live);
      repeat (3) @(negedge clk);
    end
    if (live) begin
      while (cyc < rdy_at + 4) @(negedge clk);
      chk("R10", "sec_unlocked", 64'(sec_unlocked), 64'(e_unl));
    end else begin
      repeat (20) @(negedge clk);
      chk("R2", "mon_active stays low", 64'(mon_active), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; por_flag = 1'b0; irq_lvl = 2'b00; clk_sel = 1'b0;
    vec_erased = 1'b0; sec_pass = 1'b0; host = 1'b1; baud_div = 16'(D);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mon_active", 64'(mon_active), 0);
    chk("R1", "ser_pull_low", 64'(ser_pull_low), 0);
    chk("R1", "sec_valid", 64'(sec_valid), 0);
    chk("R1", "cmd_ready", 64'(cmd_ready), 0);
    chk("R1", "sec_data", sec_data, 0);
    chk("R1", "clock outputs", 64'({use_int_clk, ref_fast, sec_unlocked, frame_err}), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    repeat (2) @(negedge clk);

    // R3 test level, slow reference, framing error on third byte, pass
    sec_pass = 1'b1; sec_tag = "R8";
    enter(1, 2'b10, 0, 0, 1, 0, 0, 0, "R3");
    run_bytes(1, 2, -1, -1, 1, 1);
    pin_reset();

    // R4 erased, normal high; glitch inside a data bit (R11); fail result
    sec_pass = 1'b0; sec_tag = "R11";
    enter(1, 2'b01, 1, 0, 1, 0, 0, 1, "R4");
    run_bytes(2, -1, 4, 3, 1, 0);
    pin_reset();

    // R4 erased, low level selects internal clock
    sec_pass = 1'b1; sec_tag = "R6";
    enter(1, 2'b00, 1, 1, 1, 0, 1, 0, "R4");
    run_bytes(3, -1, -1, -1, 1, 1);
    pin_reset();

    // R3 fast reference with clk_sel high
    enter(1, 2'b10, 0, 1, 1, 0, 0, 1, "R3");
    pin_reset();

    // R3 not erased with normal high: no entry, bytes ignored
    enter(1, 2'b01, 0, 0, 0, 0, 0, 0, "R3");
    run_bytes(4, -1, -1, -1, 0, 0);
    pin_reset();

    // R2 no power-on reset
    enter(0, 2'b10, 0, 0, 0, 0, 0, 0, "R2");
    pin_reset();

    // R4 erased with test level and with invalid code
    enter(1, 2'b10, 1, 0, 0, 0, 0, 0, "R4");
    pin_reset();
    enter(1, 2'b11, 1, 0, 0, 0, 0, 0, "R4");
    pin_reset();

    // R5 guard window: low inside, at the last edge, and just after
    enter(1, 2'b10, 0, 0, 1, 10, 0, 0, "R5");
    pin_reset();
    enter(1, 2'b10, 0, 0, 1, 24, 0, 0, "R5");
    pin_reset();
    enter(1, 2'b10, 0, 1, 1, 25, 0, 1, "R5");
    pin_reset();

    finished = 1'b1;
    summary();
  end

endmodule